// File: doc/BRIEF.md
# Programmable PIO Bus Cycle Timer

This block turns a single host request into one timed programmed-I/O cycle on an external peripheral bus. The host pulses a request with an address, a direction and write data. The block then holds chip select across three phases: setup, strobe and recovery. It pulses ready once the cycle is over. On a read it returns the captured data.

A 15-bit timing word sets the length of each phase. The strobe phase has one length for reads and another for writes. The same word selects 8-bit or 16-bit transfers, byte-lane swapping and parity checking on read data. The word, the direction, the address and the write data are all captured when the request is accepted. Changes that arrive while a cycle runs therefore cannot disturb it.

The controller is a five-state machine:
- IDLE goes to SETUP when a request arrives.
- SETUP goes to STROBE when its count expires.
- STROBE goes to RECOVER when its count expires.
- RECOVER goes to DONE when its count expires.
- DONE always goes back to IDLE.

Top module: `pio_cycle_timer`

## Requirements
- R1: One access holds chip select high without a gap through SETUP, STROBE and RECOVER, in that order. The read strobe (for reads) or the write strobe (for writes) is high only during STROBE, and the two strobes are never high together.
- R2: The lengths in cycles come from the timing word. SETUP uses bits [11:9]. STROBE uses bits [4:2] for a write and bits [8:5] for a read. RECOVER uses bits [1:0]. A programmed value of zero still gives one cycle.
- R3: Ready is high for exactly one cycle, the first cycle after chip select falls. Chip select stays low in the cycle after ready.
- R4: Bit 12 set selects 16-bit transfers using both byte lanes. Bit 12 clear selects 8-bit transfers: only one lane carries data, the unused bus lane is driven 0, and read data returns in bits [7:0] with [15:8] zero.
- R5: Bit 13 set swaps the lanes. In 16-bit mode the two bytes trade places in both directions. In 8-bit mode the byte uses bus lane [15:8] instead of [7:0].
- R6: During a write, each outgoing parity bit is the odd parity of its byte lane: bus_par_o[k] = XNOR of bus_dout_o[8k+7:8k].
- R7: When bit 14 is set, a read checks odd parity on each active lane. A mismatch sets a sticky error flag and the interrupt output, and only reset clears them. When bit 14 is clear, parity is not checked.
- R8: Read data and parity are sampled in the last STROBE cycle. Bus changes during RECOVER do not affect the returned data.
- R9: A request is accepted only in IDLE. Requests that arrive during an access or during its ready cycle are ignored. Changes to the timing word during an access do not affect that access. The address stays stable while chip select is high.
- R10: During a write, the bus output enable is high for the whole access and the write data stays stable. During a read, the output enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 15 | Timing and mode word |
| req_valid_i | input | 1 | Request pulse |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Peripheral register address |
| req_wdata_i | input | 16 | Write data |
| req_ready_o | output | 1 | Access complete pulse |
| req_rdata_o | output | 16 | Read data |
| par_err_o | output | 1 | Sticky parity error |
| irq_o | output | 1 | Interrupt, raised on parity error |
| bus_cs_o | output | 1 | Chip select |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_oe_o | output | 1 | Data output enable |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_dout_o | output | 16 | Bus write data |
| bus_par_o | output | 2 | Write parity per lane |
| bus_din_i | input | 16 | Bus read data |
| bus_par_i | input | 2 | Read parity per lane |

## Verification
Two collisions are provoked on purpose.

The first puts a fresh request on the exact cycle in which ready is high. The bench judges it by seeing chip select stay low for the following two cycles.

The second sends a new request and an inverted timing word in the cycle after acceptance. The bench judges it by measuring unchanged phase lengths and address.

Read sampling is also stressed at the boundary of the strobe phase. The bus data is inverted on the first recovery cycle, and the returned word must still match the value present during the strobe.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

    localparam int CNT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER,
        ST_DONE
    } pio_state_e;

    // Field positions follow the timing word layout (bit 14 down to bit 0).
    typedef struct packed {
        logic       par_en;   // [14]
        logic       swap;     // [13]
        logic       half;     // [12]
        logic [2:0] p1;       // [11:9]
        logic [3:0] p2_rd;    // [8:5]
        logic [2:0] p2_wr;    // [4:2]
        logic [1:0] p3;       // [1:0]
    } pio_cfg_t;

    // Terminal count of a phase: zero behaves as one cycle.
    function automatic logic [CNT_W-1:0] phase_last(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

endpackage

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
    import pio_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] p1_len_i,
    input  logic [CNT_W-1:0] p2_len_i,
    input  logic [CNT_W-1:0] p3_len_i,
    output pio_state_e       state_o,
    output logic             cs_o,
    output logic             strobe_o,
    output logic             done_o,
    output logic             last_strobe_o
);

    pio_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] len_cur;
    logic             phase_end;

    always_comb begin
        unique case (state_q)
            ST_SETUP:   len_cur = p1_len_i;
            ST_STROBE:  len_cur = p2_len_i;
            ST_RECOVER: len_cur = p3_len_i;
            default:    len_cur = '0;
        endcase
    end

    assign phase_end = (cnt_q == phase_last(len_cur));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start_i) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (phase_end) begin
                    state_d = ST_STROBE;
                    cnt_d   = '0;
                end
            end
            ST_STROBE: begin
                if (phase_end) begin
                    state_d = ST_RECOVER;
                    cnt_d   = '0;
                end
            end
            ST_RECOVER: begin
                if (phase_end) begin
                    state_d = ST_DONE;
                    cnt_d   = '0;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        cs_o          = 1'b0;
        strobe_o      = 1'b0;
        done_o        = 1'b0;
        last_strobe_o = 1'b0;
        unique case (state_q)
            ST_SETUP:   cs_o = 1'b1;
            ST_STROBE: begin
                cs_o          = 1'b1;
                strobe_o      = 1'b1;
                last_strobe_o = phase_end;
            end
            ST_RECOVER: cs_o = 1'b1;
            ST_DONE:    done_o = 1'b1;
            default:    ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/pio_lane_mux.sv
module pio_lane_mux #(
    parameter int LANE_W = 8
) (
    input  logic                half_i,
    input  logic                swap_i,
    input  logic [2*LANE_W-1:0] wdata_i,
    input  logic [2*LANE_W-1:0] din_i,
    output logic [2*LANE_W-1:0] dout_o,
    output logic [2*LANE_W-1:0] rdata_o,
    output logic [1:0]          lane_en_o
);

    localparam int DW = 2 * LANE_W;

    logic [LANE_W-1:0] w_lo, w_hi, d_lo, d_hi;

    assign w_lo = wdata_i[LANE_W-1:0];
    assign w_hi = wdata_i[DW-1:LANE_W];
    assign d_lo = din_i[LANE_W-1:0];
    assign d_hi = din_i[DW-1:LANE_W];

    always_comb begin
        if (half_i) begin
            lane_en_o = 2'b11;
            dout_o    = swap_i ? {w_lo, w_hi} : {w_hi, w_lo};
            rdata_o   = swap_i ? {d_lo, d_hi} : {d_hi, d_lo};
        end else if (swap_i) begin
            lane_en_o = 2'b10;
            dout_o    = {w_lo, {LANE_W{1'b0}}};
            rdata_o   = {{LANE_W{1'b0}}, d_hi};
        end else begin
            lane_en_o = 2'b01;
            dout_o    = {{LANE_W{1'b0}}, w_lo};
            rdata_o   = {{LANE_W{1'b0}}, d_lo};
        end
    end

endmodule

// File: rtl/pio_lane_parity.sv
module pio_lane_parity #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] dout_i,
    input  logic [LANES*LANE_W-1:0] din_i,
    input  logic [LANES-1:0]        par_in_i,
    input  logic [LANES-1:0]        lane_en_i,
    output logic [LANES-1:0]        par_out_o,
    output logic                    mismatch_o
);

    logic [LANES-1:0] bad;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par_out_o[g] = ~^dout_i[g*LANE_W +: LANE_W];
        assign bad[g]       = lane_en_i[g] &&
                              (par_in_i[g] != ~^din_i[g*LANE_W +: LANE_W]);
    end

    assign mismatch_o = |bad;

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
    import pio_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [14:0]         cfg_i,
    input  logic                req_valid_i,
    input  logic                req_write_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic [2*LANE_W-1:0] req_wdata_i,
    output logic                req_ready_o,
    output logic [2*LANE_W-1:0] req_rdata_o,
    output logic                par_err_o,
    output logic                irq_o,
    output logic                bus_cs_o,
    output logic                bus_rd_o,
    output logic                bus_wr_o,
    output logic                bus_oe_o,
    output logic [ADDR_W-1:0]   bus_addr_o,
    output logic [2*LANE_W-1:0] bus_dout_o,
    output logic [1:0]          bus_par_o,
    input  logic [2*LANE_W-1:0] bus_din_i,
    input  logic [1:0]          bus_par_i
);

    localparam int LANES  = 2;
    localparam int DATA_W = LANES * LANE_W;

    pio_cfg_t          cfg_q;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              perr_q;

    pio_state_e        state;
    logic              cs, strobe, done, last_strobe, start;
    logic [CNT_W-1:0]  p1_len, p2_len, p3_len;
    logic [DATA_W-1:0] mux_dout, mux_rdata;
    logic [LANES-1:0]  lane_en;
    logic              mismatch;

    assign start = req_valid_i && (state == ST_IDLE);

    // Request snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            cfg_q   <= pio_cfg_t'(cfg_i);
            write_q <= req_write_i;
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
        end
    end

    assign p1_len = CNT_W'(cfg_q.p1);
    assign p2_len = write_q ? CNT_W'(cfg_q.p2_wr) : CNT_W'(cfg_q.p2_rd);
    assign p3_len = CNT_W'(cfg_q.p3);

    pio_phase_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .p1_len_i      (p1_len),
        .p2_len_i      (p2_len),
        .p3_len_i      (p3_len),
        .state_o       (state),
        .cs_o          (cs),
        .strobe_o      (strobe),
        .done_o        (done),
        .last_strobe_o (last_strobe)
    );

    pio_lane_mux #(.LANE_W(LANE_W)) u_mux (
        .half_i    (cfg_q.half),
        .swap_i    (cfg_q.swap),
        .wdata_i   (wdata_q),
        .din_i     (bus_din_i),
        .dout_o    (mux_dout),
        .rdata_o   (mux_rdata),
        .lane_en_o (lane_en)
    );

    pio_lane_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_par (
        .dout_i     (mux_dout),
        .din_i      (bus_din_i),
        .par_in_i   (bus_par_i),
        .lane_en_i  (lane_en),
        .par_out_o  (bus_par_o),
        .mismatch_o (mismatch)
    );

    // Read capture on the final strobe cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            perr_q  <= 1'b0;
        end else if (last_strobe && !write_q) begin
            rdata_q <= mux_rdata;
            if (cfg_q.par_en && mismatch) perr_q <= 1'b1;
        end
    end

    assign req_ready_o = done;
    assign req_rdata_o = rdata_q;
    assign par_err_o   = perr_q;
    assign irq_o       = perr_q;
    assign bus_cs_o    = cs;
    assign bus_rd_o    = strobe && !write_q;
    assign bus_wr_o    = strobe && write_q;
    assign bus_oe_o    = cs && write_q;
    assign bus_addr_o  = addr_q;
    assign bus_dout_o  = mux_dout;

endmodule

// File: rtl/pio_timer_chk.sv
module pio_timer_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              rd,
    input logic              wr,
    input logic              oe,
    input logic              ready,
    input logic              par_err,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dout
);

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd || wr) |-> cs);                                          // R1
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr));                                                // R1
    AST_READY_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!cs && $past(cs)));                               // R3
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> (!ready && !cs));                                  // R3
    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> par_err);                                        // R7
    AST_PERR_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err) |-> $past(rd));                               // R7
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && $past(cs)) |-> $stable(addr));                        // R9
    AST_WR_OE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> oe);                                                  // R10
    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && $past(wr)) |-> $stable(dout));                        // R10

endmodule

bind pio_cycle_timer pio_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(2*LANE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (bus_cs_o),
    .rd      (bus_rd_o),
    .wr      (bus_wr_o),
    .oe      (bus_oe_o),
    .ready   (req_ready_o),
    .par_err (par_err_o),
    .addr    (bus_addr_o),
    .dout    (bus_dout_o)
);

// File: tb/tb_pio_cycle_timer.sv
module tb_pio_cycle_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] cfg_i = '0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [7:0]  req_addr_i = '0;
    logic [15:0] req_wdata_i = '0;
    logic        req_ready_o;
    logic [15:0] req_rdata_o;
    logic        par_err_o, irq_o;
    logic        bus_cs_o, bus_rd_o, bus_wr_o, bus_oe_o;
    logic [7:0]  bus_addr_o;
    logic [15:0] bus_dout_o;
    logic [1:0]  bus_par_o;
    logic [15:0] bus_din_i = '0;
    logic [1:0]  bus_par_i = '0;

    pio_cycle_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .req_ready_o(req_ready_o), .req_rdata_o(req_rdata_o),
        .par_err_o(par_err_o), .irq_o(irq_o),
        .bus_cs_o(bus_cs_o), .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o),
        .bus_oe_o(bus_oe_o), .bus_addr_o(bus_addr_o), .bus_dout_o(bus_dout_o),
        .bus_par_o(bus_par_o), .bus_din_i(bus_din_i), .bus_par_i(bus_par_i)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        bit          wr;
        int          p1, p2, p3;
        logic [15:0] rdata;
        logic [15:0] dout;
        logic [1:0]  par;
        logic [7:0]  addr;
        bit          perr;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   perr_model = 0;
    bit   finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [14:0] mk(bit pen, bit sw, bit half, int p1, int p2r,
                                       int p2w, int p3);
        return {pen, sw, half, 3'(p1), 4'(p2r), 3'(p2w), 2'(p3)};
    endfunction

    function automatic int eff(int n);
        return (n == 0) ? 1 : n;
    endfunction

    // Driver: pushes the expected result, then runs one access
    task automatic access(input logic [14:0] cfg, input bit wr, input logic [7:0] addr,
                          input logic [15:0] wd, input logic [15:0] din,
                          input bit bad_par, input bit disturb, input bit late_req);
        exp_t e;
        bit half = cfg[12];
        bit sw   = cfg[13];
        bit pen  = cfg[14];
        logic [1:0] gp;
        int lane;
        e.wr   = wr;
        e.addr = addr;
        e.p1   = eff(int'(cfg[11:9]));
        e.p2   = wr ? eff(int'(cfg[4:2])) : eff(int'(cfg[8:5]));
        e.p3   = eff(int'(cfg[1:0]));
        if (half) e.dout = sw ? {wd[7:0], wd[15:8]} : wd;
        else      e.dout = sw ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]};
        e.par = {~^e.dout[15:8], ~^e.dout[7:0]};
        if (half) e.rdata = sw ? {din[7:0], din[15:8]} : din;
        else      e.rdata = sw ? {8'h00, din[15:8]} : {8'h00, din[7:0]};
        gp   = {~^din[15:8], ~^din[7:0]};
        lane = half ? 0 : (sw ? 1 : 0);
        if (bad_par) gp[lane] = ~gp[lane];
        if (!wr && pen && bad_par) perr_model = 1;
        e.perr = perr_model;
        q.push_back(e);

        @(negedge clk);
        cfg_i = cfg; req_write_i = wr; req_addr_i = addr; req_wdata_i = wd;
        bus_din_i = din; bus_par_i = gp; req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        if (disturb) begin
            req_valid_i = 1'b1; req_addr_i = ~addr; cfg_i = ~cfg;
            req_write_i = ~wr;
            @(negedge clk);
            req_valid_i = 1'b0;
        end
        while (!req_ready_o) @(negedge clk);
        if (late_req) begin
            req_valid_i = 1'b1;               // collides with ready cycle
            @(negedge clk);
            req_valid_i = 1'b0;
            chk(!bus_cs_o, "R9 request in ready cycle", 32'(bus_cs_o), 0);
            @(negedge clk);
            chk(!bus_cs_o, "R3 no access after ready", 32'(bus_cs_o), 0);
        end else begin
            @(negedge clk);
        end
    endtask

    // Monitor: measures each access at the bus and compares on ready
    bit          in_acc = 0, seen_str = 0, str_done = 0, was_wr = 0, was_rd = 0;
    bit          order_bad = 0, oe_bad = 0, addr_bad = 0;
    int          c1, c2, c3;
    logic [15:0] cap_dout;
    logic [1:0]  cap_par;
    logic [7:0]  cap_addr;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (bus_cs_o) begin
                if (!in_acc) begin
                    in_acc = 1; seen_str = 0; str_done = 0; was_wr = 0; was_rd = 0;
                    order_bad = 0; oe_bad = 0; addr_bad = 0;
                    c1 = 0; c2 = 0; c3 = 0; cap_addr = bus_addr_o;
                end
                if (bus_addr_o != cap_addr) addr_bad = 1;
                if (bus_rd_o || bus_wr_o) begin
                    if (str_done) order_bad = 1;
                    seen_str = 1; c2++;
                    if (bus_wr_o) begin
                        was_wr = 1; cap_dout = bus_dout_o; cap_par = bus_par_o;
                    end
                    if (bus_rd_o) was_rd = 1;
                end else if (seen_str) begin
                    if (!str_done && was_rd) begin
                        bus_din_i = ~bus_din_i;   // disturb after sampling point
                        bus_par_i = ~bus_par_i;
                    end
                    str_done = 1; c3++;
                end else begin
                    c1++;
                end
                if (was_wr != bus_oe_o && seen_str) oe_bad = 1;
            end else if (in_acc) begin
                exp_t e;
                in_acc = 0;
                chk(req_ready_o == 1'b1, "R3 ready after cs falls", 32'(req_ready_o), 1);
                if (q.size() == 0) begin
                    chk(0, "R9 unexpected access", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk(!order_bad && (e.wr ? (was_wr && !was_rd) : (was_rd && !was_wr)),
                        "R1 phase order and strobe", {was_wr, was_rd}, {e.wr, !e.wr});
                    chk(c1 == e.p1, "R2 setup length", c1, e.p1);
                    chk(c2 == e.p2, "R2 strobe length", c2, e.p2);
                    chk(c3 == e.p3, "R2 recover length", c3, e.p3);
                    chk(!addr_bad && cap_addr == e.addr, "R9 address", cap_addr, e.addr);
                    chk(!oe_bad, "R10 output enable", 32'(oe_bad), 0);
                    if (e.wr) begin
                        chk(cap_dout == e.dout, "R4 R5 write data lanes", cap_dout, e.dout);
                        chk(cap_par == e.par, "R6 write parity", cap_par, e.par);
                    end else begin
                        chk(req_rdata_o == e.rdata, "R8 read data", req_rdata_o, e.rdata);
                    end
                    chk(par_err_o == e.perr && irq_o == e.perr, "R7 parity flag",
                        {irq_o, par_err_o}, {e.perr, e.perr});
                end
            end else if (req_ready_o) begin
                chk(0, "R3 spurious ready", 1, 0);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            finished = 1;
            chk(0, "watchdog", cyc, 50000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_cs_o && !bus_rd_o && !bus_wr_o, "R1 reset bus idle", 32'(bus_cs_o), 0);
        chk(!req_ready_o, "R3 reset ready", 32'(req_ready_o), 0);
        chk(!par_err_o && !irq_o, "R7 reset flag", 32'(par_err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 halfword write, no swap
        access(mk(0,0,1, 2,1,3,1), 1, 8'h12, 16'hA55C, 16'h0, 0, 0, 0);
        // R4 R7 halfword read, parity good
        access(mk(1,0,1, 1,5,2,2), 0, 8'h34, 16'h0, 16'hC381, 0, 0, 0);
        // R5 byte read on upper lane
        access(mk(1,1,0, 3,2,1,0), 0, 8'h56, 16'h0, 16'h7E01, 0, 0, 0);
        // R5 byte write on upper lane
        access(mk(0,1,0, 1,1,4,3), 1, 8'h78, 16'hFF96, 16'h0, 0, 0, 0);
        // R5 halfword swap both directions
        access(mk(0,1,1, 2,3,2,1), 1, 8'h9A, 16'h1203, 16'h0, 0, 0, 0);
        access(mk(0,1,1, 2,3,2,1), 0, 8'h9B, 16'h0, 16'hBEEF, 0, 0, 0);
        // R2 all-zero counts give one cycle each
        access(mk(0,0,1, 0,0,0,0), 0, 8'h01, 16'h0, 16'h4321, 0, 0, 0);
        access(mk(0,0,0, 0,0,0,0), 1, 8'h02, 16'h00C3, 16'h0, 0, 0, 0);
        // R2 maximum counts
        access(mk(0,0,1, 7,15,7,3), 0, 8'hF0, 16'h0, 16'h0F0F, 0, 0, 0);
        access(mk(0,0,1, 7,15,7,3), 1, 8'hF1, 16'h8001, 16'h0, 0, 0, 0);
        // R7 bad parity ignored when checking is off
        access(mk(0,0,1, 1,2,1,1), 0, 8'h20, 16'h0, 16'h1111, 1, 0, 0);
        // R7 bad parity on byte lane sets flag
        access(mk(1,0,0, 1,2,1,1), 0, 8'h21, 16'h0, 16'h0022, 1, 0, 0);
        // R7 flag stays after a clean read
        access(mk(1,0,1, 1,2,1,1), 0, 8'h22, 16'h0, 16'h3344, 0, 0, 0);
        // R9 request and timing change while busy
        access(mk(0,0,1, 3,4,2,2), 1, 8'h40, 16'h5A5A, 16'h0, 0, 1, 0);
        // R3 R9 request collides with ready
        access(mk(0,0,1, 1,1,1,1), 0, 8'h41, 16'h0, 16'h6789, 0, 0, 1);
        repeat (2) @(negedge clk);
        chk(q.size() == 0, "R9 all accesses seen", q.size(), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule